// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block is the digital control side of a successive-approximation analog-to-digital converter. A processor sets it up through a small register port with four byte-wide locations: control/status, channel select, and the result split into low and high bytes. The block starts conversions on an external converter through a start/done/result handshake. It tracks single-shot and continuous (free-running) operation. It latches the channel code only when a conversion is launched, captures each result in one step, and raises a completion flag that can drive an interrupt line.

The 3-bit channel code goes to the converter unchanged. Codes with the top bit set select a differential pair with gain, and one of those codes ties both inputs to the same pin so the offset can be measured. All of that decoding belongs to the analog side. The sequencer itself only makes sure that a code written during a conversion is not used until the next launch.

Top module: `conv_sequencer`

## Requirements
- R1: After reset, and after a reset applied during a conversion, all four locations read 0, and `irq`, `cv_enable` and `cv_start` are 0.
- R2: The enable bit (control bit 0) drives `cv_enable`. Clearing it during a conversion aborts that conversion. The start bit then reads 0, no completion is recorded, and the result keeps its old value.
- R3: With free-running off, writing 1 to the start bit (control bit 1) while enabled makes `cv_start` pulse high for one cycle, in the cycle after the write edge. The start bit reads 1 until that conversion completes and 0 afterwards, and no further conversion is launched.
- R4: With the free-running bit (control bit 2) set, each completion launches the next conversion on the same edge. The start bit stays 1 and the result is updated at every completion.
- R5: Writing 0 to the start bit has no effect. Clearing the free-running bit lets the conversion in progress finish, and then the start bit clears and no new conversion is launched.
- R6: `cv_chan` takes the select register's value only on a launch. A select write during a conversion leaves `cv_chan` unchanged until the next launch.
- R7: The select location (address 1) reads back the written code in bits 2..0, and bits 7..3 always read 0. The control location (address 0) reads 0 in bits 7..5.
- R8: The completion flag (control bit 3) sets on the edge after the converter's `cv_done` pulse. Writing 1 to it clears it, and writing 0 leaves it as it is. If a completion and a clearing write fall on the same edge, the completion wins.
- R9: `irq` is high exactly while the completion flag and the interrupt-enable bit (control bit 4) are both 1.
- R10: The result is captured from `cv_result` at completion and held until the next completion. Address 2 returns bits 7..0 of the result, and address 3 returns the remaining upper bits, zero-extended.
- R11: A write of 1 to the start bit while the enable bit is being written or held at 0 starts nothing, and the start bit reads 0.
- R12: A `cv_done` pulse while no conversion is in progress is ignored. The flag stays as it is and the result is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register location: 0 control, 1 select, 2 result low, 3 result high |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for `bus_addr` |
| irq | output | 1 | Interrupt request |
| cv_enable | output | 1 | Converter power/enable |
| cv_start | output | 1 | One-cycle conversion launch pulse |
| cv_chan | output | SEL_W | Channel/gain code latched at launch |
| cv_done | input | 1 | Converter completion pulse |
| cv_result | input | RES_W | Converter result, valid with `cv_done` |

## Verification
A register write takes effect on the rising edge that samples it. `bus_rdata` shows the addressed location one edge later, as it stood at that edge. The `cv_start` pulse appears one edge after the start write. The flag, result and `irq` all change on the edge after `cv_done` is seen high, and in free-running mode the next `cv_start` appears on that same edge. The bench drives every input on falling edges and samples one falling edge after the rising edge where each result is due. It waits for `cv_done` at a falling edge and steps exactly one more edge before checking what completion produced.

// File: rtl/conv_seq_pkg.sv
`timescale 1ns/1ps
package conv_seq_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] LOC_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] LOC_SEL  = 2'd1;
  localparam logic [ADDR_W-1:0] LOC_RLO  = 2'd2;
  localparam logic [ADDR_W-1:0] LOC_RHI  = 2'd3;

  localparam int BIT_EN   = 0;
  localparam int BIT_GO   = 1;
  localparam int BIT_FR   = 2;
  localparam int BIT_FLAG = 3;
  localparam int BIT_IE   = 4;
  localparam int CTRL_USED = 5;

  typedef enum logic [0:0] {
    SEQ_IDLE,
    SEQ_BUSY
  } seq_state_t;
endpackage

// File: rtl/conv_ctrl_regs.sv
`timescale 1ns/1ps
module conv_ctrl_regs
  import conv_seq_pkg::*;
#(
  parameter int SEL_W = 3,
  parameter int RES_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              set_flag_i,
  input  logic              clr_go_i,
  input  logic [RES_W-1:0]  result_i,
  output logic              en_o,
  output logic              go_o,
  output logic              fr_o,
  output logic              flag_o,
  output logic              ie_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic              irq_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int WIDE_W = 2 * DATA_W;

  logic wr_ctrl, wr_sel;
  logic en_q, go_q, fr_q, flag_q, ie_q;
  logic en_d, go_d, fr_d, flag_d, ie_d;
  logic [SEL_W-1:0]  sel_q;
  logic [DATA_W-1:0] ctrl_view, sel_view, rd_mux;
  logic [WIDE_W-1:0] res_wide;
  logic              unused_wbits;

  assign wr_ctrl = wr_i && (addr_i == LOC_CTRL);
  assign wr_sel  = wr_i && (addr_i == LOC_SEL);
  assign unused_wbits = ^wdata_i[DATA_W-1:CTRL_USED];

  always_comb begin
    en_d = wr_ctrl ? wdata_i[BIT_EN] : en_q;
    fr_d = wr_ctrl ? wdata_i[BIT_FR] : fr_q;
    ie_d = wr_ctrl ? wdata_i[BIT_IE] : ie_q;
    if (!en_d)                         go_d = 1'b0;
    else if (wr_ctrl && wdata_i[BIT_GO]) go_d = 1'b1;
    else if (clr_go_i)                 go_d = 1'b0;
    else                               go_d = go_q;
    if (set_flag_i)                      flag_d = 1'b1;
    else if (wr_ctrl && wdata_i[BIT_FLAG]) flag_d = 1'b0;
    else                                 flag_d = flag_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      go_q   <= 1'b0;
      fr_q   <= 1'b0;
      flag_q <= 1'b0;
      ie_q   <= 1'b0;
      irq_o  <= 1'b0;
      sel_q  <= '0;
    end else begin
      en_q   <= en_d;
      go_q   <= go_d;
      fr_q   <= fr_d;
      flag_q <= flag_d;
      ie_q   <= ie_d;
      irq_o  <= flag_d && ie_d;
      if (wr_sel) sel_q <= wdata_i[SEL_W-1:0];
    end
  end

  always_comb begin
    ctrl_view           = '0;
    ctrl_view[BIT_EN]   = en_q;
    ctrl_view[BIT_GO]   = go_q;
    ctrl_view[BIT_FR]   = fr_q;
    ctrl_view[BIT_FLAG] = flag_q;
    ctrl_view[BIT_IE]   = ie_q;
    sel_view            = '0;
    sel_view[SEL_W-1:0] = sel_q;
    res_wide            = WIDE_W'(result_i);
    unique case (addr_i)
      LOC_CTRL: rd_mux = ctrl_view;
      LOC_SEL:  rd_mux = sel_view;
      LOC_RLO:  rd_mux = res_wide[DATA_W-1:0];
      default:  rd_mux = res_wide[WIDE_W-1:DATA_W];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= rd_mux;
  end

  assign en_o   = en_q;
  assign go_o   = go_q;
  assign fr_o   = fr_q;
  assign flag_o = flag_q;
  assign ie_o   = ie_q;
  assign sel_o  = sel_q;
endmodule

// File: rtl/conv_fsm.sv
`timescale 1ns/1ps
module conv_fsm
  import conv_seq_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             go_i,
  input  logic             fr_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             cv_done_i,
  output logic             cv_start_o,
  output logic [SEL_W-1:0] cv_chan_o,
  output logic             cmpl_o,
  output logic             clr_go_o
);
  seq_state_t st_q;
  logic       launch, finish;

  always_comb begin
    finish   = (st_q == SEQ_BUSY) && en_i && cv_done_i;
    launch   = ((st_q == SEQ_IDLE) && en_i && go_i) || (finish && fr_i);
    cmpl_o   = finish;
    clr_go_o = finish && !fr_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= SEQ_IDLE;
      cv_start_o <= 1'b0;
      cv_chan_o  <= '0;
    end else begin
      cv_start_o <= launch;
      if (launch) cv_chan_o <= sel_i;
      if (!en_i)       st_q <= SEQ_IDLE;
      else if (launch) st_q <= SEQ_BUSY;
      else if (finish) st_q <= SEQ_IDLE;
    end
  end
endmodule

// File: rtl/conv_result_hold.sv
`timescale 1ns/1ps
module conv_result_hold #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_i,
  input  logic [RES_W-1:0] data_i,
  output logic [RES_W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst)        q_o <= '0;
    else if (cap_i) q_o <= data_i;
  end
endmodule

// File: rtl/conv_sequencer.sv
`timescale 1ns/1ps
module conv_sequencer
  import conv_seq_pkg::*;
#(
  parameter int SEL_W = 3,
  parameter int RES_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              cv_enable,
  output logic              cv_start,
  output logic [SEL_W-1:0]  cv_chan,
  input  logic              cv_done,
  input  logic [RES_W-1:0]  cv_result
);
  logic             en_w, go_w, fr_w, flag_w, ie_w;
  logic             cmpl_w, clr_go_w;
  logic [SEL_W-1:0] sel_w;
  logic [RES_W-1:0] result_w;

  conv_ctrl_regs #(.SEL_W(SEL_W), .RES_W(RES_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_i(bus_wr), .addr_i(bus_addr), .wdata_i(bus_wdata),
    .set_flag_i(cmpl_w), .clr_go_i(clr_go_w), .result_i(result_w),
    .en_o(en_w), .go_o(go_w), .fr_o(fr_w), .flag_o(flag_w), .ie_o(ie_w),
    .sel_o(sel_w), .irq_o(irq), .rdata_o(bus_rdata)
  );

  conv_fsm #(.SEL_W(SEL_W)) u_fsm (
    .clk(clk), .rst(rst),
    .en_i(en_w), .go_i(go_w), .fr_i(fr_w), .sel_i(sel_w),
    .cv_done_i(cv_done),
    .cv_start_o(cv_start), .cv_chan_o(cv_chan),
    .cmpl_o(cmpl_w), .clr_go_o(clr_go_w)
  );

  conv_result_hold #(.RES_W(RES_W)) u_res (
    .clk(clk), .rst(rst),
    .cap_i(cmpl_w), .data_i(cv_result), .q_o(result_w)
  );

  assign cv_enable = en_w;
endmodule

// File: rtl/conv_seq_chk.sv
`timescale 1ns/1ps
module conv_seq_chk #(
  parameter int SEL_W = 3,
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             irq,
  input logic             cv_start,
  input logic [SEL_W-1:0] cv_chan,
  input logic             cv_done,
  input logic             en_w,
  input logic             go_w,
  input logic             flag_w,
  input logic             ie_w,
  input logic [RES_W-1:0] result_w
);
  assert_chan_at_launch_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(cv_chan) |-> cv_start);

  assert_irq_tracks_flag_R9: assert property (@(posedge clk) disable iff (rst)
    irq == (flag_w && ie_w));

  assert_abort_stops_R2: assert property (@(posedge clk) disable iff (rst)
    !en_w |=> !cv_start);

  assert_flag_from_done_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_w) |-> $past(cv_done));

  assert_result_held_R10: assert property (@(posedge clk) disable iff (rst)
    !$stable(result_w) |-> $past(cv_done));

  assert_go_needs_en_R11: assert property (@(posedge clk) disable iff (rst)
    go_w |-> en_w);
endmodule

bind conv_sequencer conv_seq_chk #(.SEL_W(SEL_W), .RES_W(RES_W)) u_chk (
  .clk(clk), .rst(rst), .irq(irq), .cv_start(cv_start), .cv_chan(cv_chan),
  .cv_done(cv_done), .en_w(en_w), .go_w(go_w), .flag_w(flag_w),
  .ie_w(ie_w), .result_w(result_w)
);

// File: tb/sim_conv_sequencer.sv
`timescale 1ns/1ps
module sim_conv_sequencer;
  localparam int SEL_W = 3;
  localparam int RES_W = 10;
  localparam int CONV_LEN = 12;
  localparam int NVEC = 6;
  // {address, write data, expected readback}
  localparam logic [17:0] VEC [NVEC] = '{
    {2'd1, 8'hFF, 8'h07},
    {2'd1, 8'h1D, 8'h05},
    {2'd1, 8'h18, 8'h00},
    {2'd0, 8'hFE, 8'h14},
    {2'd0, 8'h02, 8'h00},
    {2'd1, 8'h06, 8'h06}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic irq, cv_enable, cv_start, cv_done;
  logic [SEL_W-1:0] cv_chan;
  logic [RES_W-1:0] cv_result;

  logic stray = 1'b0;
  logic stub_done;
  logic [RES_W-1:0] stub_res;
  logic [SEL_W-1:0] lat_chan;
  logic [6:0] conv_no;
  int cnt;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  conv_sequencer #(.SEL_W(SEL_W), .RES_W(RES_W)) u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .cv_enable(cv_enable), .cv_start(cv_start), .cv_chan(cv_chan),
    .cv_done(cv_done), .cv_result(cv_result)
  );

  // behavioural converter: fixed length, result = {channel, running count}
  always_ff @(posedge clk) begin
    if (rst || !cv_enable) begin
      cnt <= 0;
      stub_done <= 1'b0;
      if (rst) begin
        conv_no <= '0;
        stub_res <= '0;
        lat_chan <= '0;
      end
    end else if (cv_start) begin
      cnt <= CONV_LEN;
      lat_chan <= cv_chan;
      stub_done <= 1'b0;
    end else if (cnt == 1) begin
      cnt <= 0;
      stub_done <= 1'b1;
      stub_res <= {lat_chan, conv_no};
      conv_no <= conv_no + 7'd1;
    end else begin
      if (cnt != 0) cnt <= cnt - 1;
      stub_done <= 1'b0;
    end
  end
  assign cv_done = stub_done | stray;
  assign cv_result = stub_res;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic rd_result(output logic [RES_W-1:0] r);
    logic [7:0] lo, hi;
    rd(2'd2, lo);
    rd(2'd3, hi);
    r = {hi[RES_W-9:0], lo};
    checks++;
    if (hi[7:RES_W-8] !== '0) begin
      fails++;
      $display("FAIL R10: high byte padding got %0h expected 0", hi);
    end
  endtask

  task automatic wait_done(input string req, output logic [RES_W-1:0] r);
    int n = 0;
    while (!cv_done && n < 200) begin
      @(negedge clk);
      n++;
    end
    checks++;
    if (!cv_done) begin
      fails++;
      $display("FAIL %s: converter done got 0 expected 1", req);
    end
    r = cv_result;
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] d;
    logic [RES_W-1:0] r1, r2, r3, rr;
    int seen;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset values
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk("R1", d, 0);
    end
    chk("R1", {irq, cv_enable, cv_start}, 0);

    // R7 / R11: register readback table
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][17:16], VEC[i][15:8]);
      rd(VEC[i][17:16], d);
      chk(VEC[i][17:16] == 2'd1 ? "R7" : "R11", d, VEC[i][7:0]);
    end

    // R3 single conversion, channel 6
    wr(2'd0, 8'h13);
    chk("R3", cv_start, 0);
    @(negedge clk);
    chk("R3", cv_start, 1);
    chk("R6", cv_chan, 6);
    @(negedge clk);
    chk("R3", cv_start, 0);
    wr(2'd1, 8'h02);
    chk("R6", cv_chan, 6);
    rd(2'd0, d);
    chk("R3", d, 8'h13);
    wait_done("R3", r1);
    chk("R9", irq, 1);
    rd(2'd0, d);
    chk("R3", d, 8'h19);
    rd_result(rr);
    chk("R10", rr, r1);
    chk("R6", r1[9:7], 6);
    seen = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (cv_start) seen++;
    end
    chk("R3", seen, 0);

    // R8 flag clearing
    wr(2'd0, 8'h11);
    rd(2'd0, d);
    chk("R8", d, 8'h19);
    wr(2'd0, 8'h19);
    rd(2'd0, d);
    chk("R8", d, 8'h11);
    chk("R9", irq, 0);

    // R12 stray done while idle
    stray = 1'b1;
    @(negedge clk);
    stray = 1'b0;
    @(negedge clk);
    rd(2'd0, d);
    chk("R12", d, 8'h11);
    rd_result(rr);
    chk("R12", rr, r1);

    // R4 free running, channel 2 then 5
    wr(2'd0, 8'h17);
    @(negedge clk);
    chk("R4", cv_chan, 2);
    wr(2'd1, 8'h05);
    chk("R6", cv_chan, 2);
    wait_done("R4", r1);
    chk("R4", cv_start, 1);
    chk("R6", cv_chan, 5);
    rd(2'd0, d);
    chk("R4", d, 8'h1F);
    rd_result(rr);
    chk("R4", rr, r1);
    chk("R6", r1[9:7], 2);
    wr(2'd0, 8'h15);
    rd(2'd0, d);
    chk("R5", d, 8'h1F);
    wait_done("R4", r2);
    chk("R4", cv_start, 1);
    rd_result(rr);
    chk("R4", rr, r2);
    chk("R6", r2[9:7], 5);
    chk("R4", (r2[6:0] == r1[6:0] + 7'd1), 1);
    wr(2'd0, 8'h11);
    wait_done("R5", r3);
    chk("R5", cv_start, 0);
    seen = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (cv_start) seen++;
    end
    chk("R5", seen, 0);
    rd(2'd0, d);
    chk("R5", d, 8'h19);
    rd_result(rr);
    chk("R10", rr, r3);

    // R2 abort mid-conversion
    wr(2'd0, 8'h1B);
    @(negedge clk);
    chk("R2", cv_start, 1);
    repeat (3) @(negedge clk);
    wr(2'd0, 8'h10);
    chk("R2", cv_enable, 0);
    seen = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (cv_done || cv_start) seen++;
    end
    chk("R2", seen, 0);
    rd(2'd0, d);
    chk("R2", d, 8'h10);
    rd_result(rr);
    chk("R2", rr, r3);

    // R11 start while disabled
    wr(2'd0, 8'h02);
    rd(2'd0, d);
    chk("R11", d, 8'h00);
    seen = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (cv_start) seen++;
    end
    chk("R11", seen, 0);

    // R1 reset during a conversion
    wr(2'd0, 8'h13);
    repeat (3) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk("R1", d, 0);
    end
    chk("R1", {irq, cv_enable, cv_start}, 0);

    summary();
  end
endmodule